// File: doc/BRIEF.md
# Early-Writeback Dual-Port Register File

This block is the integer register file for a six-stage in-order pipeline with the stages fetch, decode, execute, two memory stages and writeback. Arithmetic results do not wait for writeback. They go into the array through a dedicated port at the end of execute. Load results arrive three cycles later and use the normal port at writeback. Because of this, a younger arithmetic instruction can reach the array before an older load that targets the same register.

The block follows every in-flight load from the first memory stage to writeback. Each load carries a kill flag, which is set when a younger arithmetic instruction writes that load's destination first. When both ports target one register in the same edge, the arithmetic port wins. The result is that the architectural state always matches program order.

An address fault is detected at the start of the second memory stage. By then a younger arithmetic instruction may already have changed the state. The block raises an imprecise-state flag in that case. Bypass paths, stalls and exception recovery are left to the surrounding pipeline.

Top module: `ewrf_top`

## Requirements
- R1: After reset every register reads as zero on both read ports.
- R2: A write takes effect at a rising clock edge. The new value is visible on the read ports only from the cycle that follows; the read ports do not forward write data.
- R3: When `ex_alu_we` is high, `ex_alu_data` is written to register `ex_alu_rd` at the end of that cycle.
- R4: A load issued with `ex_ld_issue` and `ex_ld_rd` in cycle t reaches writeback in cycle t+3. In that cycle `wb_ld_data` is written to its destination, unless R6 or R7 applies.
- R5: Register 0 always reads zero. Writes to it from either port are ignored.
- R6: When the writeback load and the arithmetic instruction target the same register in one cycle, the register takes the arithmetic value.
- R7: When an arithmetic instruction writes register r while an older load to r is in the first or second memory stage, that load's later writeback write is dropped.
- R8: `imprecise` is high exactly in the cycles where `m2_fault` is high and an arithmetic instruction with a nonzero destination is in execute or was in execute the previous cycle.
- R9: The two read ports return the contents of arbitrary, independent addresses in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_addr_a | input | 5 | Read port A address |
| rd_data_a | output | 32 | Read port A data |
| rd_addr_b | input | 5 | Read port B address |
| rd_data_b | output | 32 | Read port B data |
| ex_alu_we | input | 1 | Arithmetic instruction in execute writes a result |
| ex_alu_rd | input | 5 | Its destination register |
| ex_alu_data | input | 32 | Its result |
| ex_ld_issue | input | 1 | Load leaves execute this cycle (exclusive with ex_alu_we) |
| ex_ld_rd | input | 5 | Destination register of that load |
| wb_ld_data | input | 32 | Data of the load now in writeback |
| m2_fault | input | 1 | Address fault of the instruction in the second memory stage |
| imprecise | output | 1 | State already changed by a younger instruction at the fault |

## Verification
Two events can fall in the same clock edge: the writeback of an older load and the early write of a younger arithmetic instruction. They collide when both name one register, or when the arithmetic instruction passes a load that is still in a memory stage. The bench issues loads and arithmetic operations into a small register window so that these overlaps occur often. It adds directed sequences that place the arithmetic instruction exactly in the writeback cycle of the load, and one and two cycles earlier than that. The result is judged by comparing both read ports in every cycle against a reference that applies a write only when its sequence number is newer than the last one recorded for that register.

// File: rtl/ewrf_pkg.sv
package ewrf_pkg;
  parameter int unsigned RF_DEPTH = 32;
  parameter int unsigned RF_WIDTH = 32;
  localparam int unsigned RF_AW = $clog2(RF_DEPTH);

  typedef logic [RF_AW-1:0]    reg_addr_t;
  typedef logic [RF_WIDTH-1:0] reg_data_t;

  typedef struct packed {
    logic      vld;
    reg_addr_t rd;
    logic      kill;
  } ld_slot_t;
endpackage

// File: rtl/ewrf_array.sv
module ewrf_array
  import ewrf_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wen_ld,
  input  reg_addr_t waddr_ld,
  input  reg_data_t wdata_ld,
  input  logic      wen_alu,
  input  reg_addr_t waddr_alu,
  input  reg_data_t wdata_alu,
  input  reg_addr_t raddr_a,
  output reg_data_t rdata_a,
  input  reg_addr_t raddr_b,
  output reg_data_t rdata_b
);
  reg_data_t regs [RF_DEPTH];

  assign regs[0] = '0;

  for (genvar gi = 1; gi < RF_DEPTH; gi++) begin : g_reg
    logic      sel_ld, sel_alu, en;
    reg_data_t d, q;

    always_comb begin
      sel_ld  = wen_ld  && (waddr_ld  == reg_addr_t'(gi));
      sel_alu = wen_alu && (waddr_alu == reg_addr_t'(gi));
      en      = sel_ld || sel_alu;
      d       = sel_alu ? wdata_alu : wdata_ld;   // younger port wins
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign regs[gi] = q;
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/ewrf_ld_track.sv
module ewrf_ld_track
  import ewrf_pkg::*;
#(
  parameter int unsigned LD_DEPTH = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ld_issue,
  input  reg_addr_t ld_rd,
  input  logic      alu_we,
  input  reg_addr_t alu_rd,
  output ld_slot_t  slot_q [LD_DEPTH],
  output logic      wb_wen,
  output reg_addr_t wb_rd
);
  localparam int unsigned WB_IDX = LD_DEPTH - 1;

  ld_slot_t slot_d [LD_DEPTH];
  logic     alu_live;

  assign alu_live = alu_we && (alu_rd != '0);

  always_comb begin
    slot_d[0].vld  = ld_issue;
    slot_d[0].rd   = ld_rd;
    slot_d[0].kill = 1'b0;
  end

  for (genvar gs = 1; gs < LD_DEPTH; gs++) begin : g_stage
    logic hit;
    assign hit = alu_live && slot_q[gs-1].vld && (slot_q[gs-1].rd == alu_rd);
    always_comb begin
      slot_d[gs]      = slot_q[gs-1];
      slot_d[gs].kill = slot_q[gs-1].kill || hit;
    end
  end

  for (genvar gr = 0; gr < LD_DEPTH; gr++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[gr] <= '0;
      else        slot_q[gr] <= slot_d[gr];
    end
  end

  assign wb_wen = slot_q[WB_IDX].vld && !slot_q[WB_IDX].kill && (slot_q[WB_IDX].rd != '0);
  assign wb_rd  = slot_q[WB_IDX].rd;
endmodule

// File: rtl/ewrf_fault_flag.sv
module ewrf_fault_flag
  import ewrf_pkg::*;
#(
  parameter int unsigned FAULT_LAG = 1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      alu_we,
  input  reg_addr_t alu_rd,
  input  logic      fault,
  output logic      imprecise
);
  logic                 alu_live;
  logic [FAULT_LAG-1:0] hist_d, hist_q;

  assign alu_live = alu_we && (alu_rd != '0);

  always_comb begin
    if (FAULT_LAG > 1) hist_d = {hist_q[FAULT_LAG-2:0], alu_live};
    else               hist_d = alu_live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  assign imprecise = fault && (alu_live || (|hist_q));
endmodule

// File: rtl/ewrf_top.sv
module ewrf_top
  import ewrf_pkg::*;
#(
  parameter int unsigned LD_DEPTH  = 3,
  parameter int unsigned FAULT_LAG = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [RF_AW-1:0]    rd_addr_a,
  output logic [RF_WIDTH-1:0] rd_data_a,
  input  logic [RF_AW-1:0]    rd_addr_b,
  output logic [RF_WIDTH-1:0] rd_data_b,
  input  logic                ex_alu_we,
  input  logic [RF_AW-1:0]    ex_alu_rd,
  input  logic [RF_WIDTH-1:0] ex_alu_data,
  input  logic                ex_ld_issue,
  input  logic [RF_AW-1:0]    ex_ld_rd,
  input  logic [RF_WIDTH-1:0] wb_ld_data,
  input  logic                m2_fault,
  output logic                imprecise
);
  ld_slot_t  trk_slot [LD_DEPTH];
  logic      trk_wb_wen;
  reg_addr_t trk_wb_rd;

  ewrf_ld_track #(.LD_DEPTH(LD_DEPTH)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_issue (ex_ld_issue),
    .ld_rd    (ex_ld_rd),
    .alu_we   (ex_alu_we),
    .alu_rd   (ex_alu_rd),
    .slot_q   (trk_slot),
    .wb_wen   (trk_wb_wen),
    .wb_rd    (trk_wb_rd)
  );

  ewrf_array u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .wen_ld    (trk_wb_wen),
    .waddr_ld  (trk_wb_rd),
    .wdata_ld  (wb_ld_data),
    .wen_alu   (ex_alu_we),
    .waddr_alu (ex_alu_rd),
    .wdata_alu (ex_alu_data),
    .raddr_a   (rd_addr_a),
    .rdata_a   (rd_data_a),
    .raddr_b   (rd_addr_b),
    .rdata_b   (rd_data_b)
  );

  ewrf_fault_flag #(.FAULT_LAG(FAULT_LAG)) u_fault (
    .clk       (clk),
    .rst_n     (rst_n),
    .alu_we    (ex_alu_we),
    .alu_rd    (ex_alu_rd),
    .fault     (m2_fault),
    .imprecise (imprecise)
  );
endmodule

// File: rtl/ewrf_chk.sv
module ewrf_chk
  import ewrf_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      alu_we,
  input reg_addr_t alu_rd,
  input reg_data_t alu_data,
  input reg_addr_t ra,
  input reg_data_t da,
  input reg_addr_t rb,
  input reg_data_t db,
  input logic      fault,
  input logic      imprecise,
  input logic      m1_vld,
  input reg_addr_t m1_rd,
  input logic      m2_vld,
  input reg_addr_t m2_rd,
  input logic      wb_wen,
  input reg_addr_t wb_rd,
  input reg_data_t wb_data
);
  AST_X0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ra == '0) |-> (da == '0)); // R5

  AST_ALU_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_we && alu_rd != '0) |=> ((ra != $past(alu_rd)) || (da == $past(alu_data)))); // R3

  AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_wen && !(alu_we && alu_rd == wb_rd)) |=> ((rb != $past(wb_rd)) || (db == $past(wb_data)))); // R4

  AST_KILL_M1: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_we && alu_rd != '0 && m1_vld && m1_rd == alu_rd) |-> ##2 !wb_wen); // R7

  AST_KILL_M2: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_we && alu_rd != '0 && m2_vld && m2_rd == alu_rd) |=> !wb_wen); // R7

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && alu_we && alu_rd != '0) |-> imprecise); // R8

  AST_FLAG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !fault |-> !imprecise); // R8
endmodule

bind ewrf_top ewrf_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .alu_we    (ex_alu_we),
  .alu_rd    (ex_alu_rd),
  .alu_data  (ex_alu_data),
  .ra        (rd_addr_a),
  .da        (rd_data_a),
  .rb        (rd_addr_b),
  .db        (rd_data_b),
  .fault     (m2_fault),
  .imprecise (imprecise),
  .m1_vld    (trk_slot[0].vld),
  .m1_rd     (trk_slot[0].rd),
  .m2_vld    (trk_slot[1].vld),
  .m2_rd     (trk_slot[1].rd),
  .wb_wen    (trk_wb_wen),
  .wb_rd     (trk_wb_rd),
  .wb_data   (wb_ld_data)
);

// File: tb/ewrf_top_tb.sv
module ewrf_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  rd_addr_a, rd_addr_b, ex_alu_rd, ex_ld_rd;
  logic [31:0] rd_data_a, rd_data_b, ex_alu_data, wb_ld_data;
  logic        ex_alu_we, ex_ld_issue, m2_fault, imprecise;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [31:0] ref_rf [32];
  int          last_seq [32];
  int          seq = 0;
  bit          pv [3];
  logic [4:0]  prd [3];
  logic [31:0] pdat [3];
  int          pseq [3];
  bit          prev_alu = 0;
  string       cur_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  ewrf_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
    .ex_alu_we(ex_alu_we), .ex_alu_rd(ex_alu_rd), .ex_alu_data(ex_alu_data),
    .ex_ld_issue(ex_ld_issue), .ex_ld_rd(ex_ld_rd), .wb_ld_data(wb_ld_data),
    .m2_fault(m2_fault), .imprecise(imprecise)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic bit flag_exp(bit fault, int kind, logic [4:0] rd);
    return fault && (prev_alu || (kind == 1 && rd != 0));
  endfunction

  // kind: 0 bubble, 1 arithmetic, 2 load
  task automatic step(int kind, logic [4:0] rd, logic [31:0] data, bit fault);
    ex_alu_we   = (kind == 1);
    ex_alu_rd   = rd;
    ex_alu_data = data;
    ex_ld_issue = (kind == 2);
    ex_ld_rd    = rd;
    wb_ld_data  = pdat[2];
    m2_fault    = fault;
    #1;
    check(cur_tag, rd_data_a, ref_rf[rd_addr_a]);
    check(cur_tag, rd_data_b, ref_rf[rd_addr_b]);
    check("R8", {31'b0, imprecise}, {31'b0, flag_exp(fault, kind, rd)});
    // reference effect of the coming edge, in program order
    if (pv[2] && prd[2] != 0 && pseq[2] > last_seq[prd[2]]) begin
      ref_rf[prd[2]] = pdat[2];
      last_seq[prd[2]] = pseq[2];
    end
    if (kind != 0) seq++;
    if (kind == 1 && rd != 0) begin
      ref_rf[rd] = data;
      last_seq[rd] = seq;
    end
    for (int s = 2; s > 0; s--) begin
      pv[s] = pv[s-1]; prd[s] = prd[s-1]; pdat[s] = pdat[s-1]; pseq[s] = pseq[s-1];
    end
    pv[0] = (kind == 2); prd[0] = rd; pdat[0] = data; pseq[0] = seq;
    prev_alu = (kind == 1 && rd != 0);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bubbles(int n);
    for (int i = 0; i < n; i++) step(0, 5'd0, 32'd0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    for (int r = 0; r < 32; r++) begin ref_rf[r] = '0; last_seq[r] = 0; end
    for (int s = 0; s < 3; s++) begin pv[s] = 0; prd[s] = '0; pdat[s] = '0; pseq[s] = 0; end
    rst_n = 1'b0;
    ex_alu_we = 0; ex_alu_rd = '0; ex_alu_data = '0;
    ex_ld_issue = 0; ex_ld_rd = '0; wb_ld_data = '0; m2_fault = 0;
    rd_addr_a = '0; rd_addr_b = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: all registers zero after reset
    cur_tag = "R1";
    for (int i = 0; i < 16; i++) begin
      rd_addr_a = 5'(2*i); rd_addr_b = 5'(2*i+1);
      step(0, 5'd0, 32'd0, 1'b0);
    end

    // R3 / R2: arithmetic write visible the following cycle only
    cur_tag = "R3"; rd_addr_a = 5'd5; rd_addr_b = 5'd5;
    step(1, 5'd5, 32'hA5A5_0001, 1'b0);
    cur_tag = "R2";
    step(0, 5'd0, 32'd0, 1'b0);
    check("R2", rd_data_a, 32'hA5A5_0001);

    // R4: load lands three cycles after issue
    cur_tag = "R4"; rd_addr_a = 5'd6; rd_addr_b = 5'd6;
    step(2, 5'd6, 32'h0BAD_0006, 1'b0);
    bubbles(3);
    check("R4", rd_data_b, 32'h0BAD_0006);
    bubbles(1);

    // R6: same-cycle collision, arithmetic wins
    cur_tag = "R6"; rd_addr_a = 5'd7; rd_addr_b = 5'd7;
    step(2, 5'd7, 32'h1111_0007, 1'b0);
    bubbles(2);
    step(1, 5'd7, 32'h2222_0007, 1'b0);
    bubbles(2);
    check("R6", rd_data_a, 32'h2222_0007);

    // R7: older load in M1 / M2 cancelled by younger arithmetic write
    cur_tag = "R7"; rd_addr_a = 5'd8; rd_addr_b = 5'd9;
    step(2, 5'd8, 32'h3333_0008, 1'b0);
    step(1, 5'd8, 32'h4444_0008, 1'b0);
    step(2, 5'd9, 32'h3333_0009, 1'b0);
    step(0, 5'd0, 32'd0, 1'b0);
    step(1, 5'd9, 32'h4444_0009, 1'b0);
    bubbles(4);
    check("R7", rd_data_a, 32'h4444_0008);
    check("R7", rd_data_b, 32'h4444_0009);

    // R5: register 0 ignores both ports
    cur_tag = "R5"; rd_addr_a = 5'd0; rd_addr_b = 5'd0;
    step(1, 5'd0, 32'hFFFF_FFFF, 1'b0);
    step(2, 5'd0, 32'hEEEE_EEEE, 1'b0);
    bubbles(4);
    check("R5", rd_data_a, 32'd0);

    // R8: fault with younger arithmetic in EX, in M1, and with none
    cur_tag = "R8"; rd_addr_a = 5'd3; rd_addr_b = 5'd4;
    step(2, 5'd2, 32'h5555_0002, 1'b0);
    step(0, 5'd0, 32'd0, 1'b0);
    step(1, 5'd3, 32'h6666_0003, 1'b1);
    step(2, 5'd2, 32'h5555_1002, 1'b0);
    step(1, 5'd4, 32'h6666_0004, 1'b0);
    step(0, 5'd0, 32'd0, 1'b1);
    step(0, 5'd0, 32'd0, 1'b1);
    check("R8", {31'b0, imprecise}, 32'd0);
    bubbles(3);

    // R9: constrained random mix in a small register window
    cur_tag = "R9";
    for (int n = 0; n < 4000; n++) begin
      int k;
      logic [4:0] rd;
      rd_addr_a = 5'($urandom % 8);
      rd_addr_b = ($urandom % 4 == 0) ? 5'($urandom % 32) : 5'($urandom % 8);
      k  = $urandom % 3;
      rd = 5'($urandom % 8);
      step(k, rd, $urandom, ($urandom % 8) == 0);
    end
    bubbles(4);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule